// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block serves one channel of a 16550-style serial port. It watches four active-low modem handshake inputs: carrier present, ring, data set ready and clear to send. It presents them to the processor as one 8-bit readable register. The upper nibble gives the live asserted state of each line. The lower nibble holds sticky change flags. A flag is set when its line moves. The whole nibble clears when the processor reads the register. While any flag is set and the modem-status interrupt enable is high, the block requests an interrupt.

For self-test, a loopback input replaces the external pins with four bits of the channel's modem control register. Change detection runs on whichever source is selected, so switching source can itself raise flags. The external inputs are asynchronous. They pass through a resynchroniser whose depth is a parameter. A changed line therefore shows in the register `SYNC_STAGES + 1` clocks after the pin moves. A loopback change shows one clock after the control bit moves.

The read port is a plain register view, not a stream. `rd_data_o` always shows the present contents. A one-cycle `rd_stb_i` marks the cycle whose contents the processor takes. The clear acts at the end of that cycle. There is no back-pressure: a read always completes in the cycle it is strobed.

Top module: `mdm_stat_reg`

## Requirements
- R1: With loopback off, register bits 7, 6, 5 and 4 equal the inverted levels of `mdm_pins_i[3]` (carrier), `mdm_pins_i[2]` (ring), `mdm_pins_i[1]` (data set ready) and `mdm_pins_i[0]` (clear to send). A pin change appears `SYNC_STAGES + 1` clocks later.
- R2: With `loop_en_i` high, bit 7 follows `ctl_i[3]`, bit 6 follows `ctl_i[2]`, bit 5 follows `ctl_i[0]` and bit 4 follows `ctl_i[1]`, one clock later. The pins then have no effect on the register.
- R3: Bits 3, 1 and 0 are change flags for bits 7, 5 and 4. A flag becomes 1 in the same clock that its status bit changes, in either direction.
- R4: Bit 2 becomes 1 only when status bit 6 goes from 1 to 0, which is the ring pin going from 0 to 1 in normal mode. A 0 to 1 move of bit 6 does not set it.
- R5: A clock with `rd_stb_i` high shows the pre-clear contents on `rd_data_o`. From the next clock, bits 3 to 0 read 0 unless a new change arrived.
- R6: A qualifying change in the same clock as a read leaves its flag at 1 after the read.
- R7: `irq_o` is high exactly when `ien_i` is high and any of bits 3 to 0 is 1. Flags still set and hold while `ien_i` is low.
- R8: After reset, with all pins held high, the register reads 0x00 and `irq_o` is 0.
- R9: Turning loopback on or off sets the change flag of every status bit whose value differs between the old source and the new one. It sets no flag where the two sources agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mdm_pins_i | input | 4 | Active-low modem inputs: [3] carrier, [2] ring, [1] data set ready, [0] clear to send (asynchronous) |
| loop_en_i | input | 1 | Loopback select from the modem control register |
| ctl_i | input | 4 | Low nibble of the modem control register used in loopback |
| ien_i | input | 1 | Modem-status interrupt enable |
| rd_stb_i | input | 1 | Address-qualified single-cycle read strobe |
| rd_data_o | output | 8 | Register contents: [7:4] line state, [3:0] change flags |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with `SYNC_STAGES` at its default of 2, so every pin change lands in the register exactly three clocks after it is driven. Because that delay is known, the bench can line up a pin edge with a read strobe in the same clock and confirm the flag survives. At this depth the bench also drives ring edges in both directions, switches loopback with sources that disagree and that agree, and toggles pins while loopback is on.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;

  localparam int LINES = 4;

  // Status bit positions within the upper/lower nibble
  localparam int IDX_SEND    = 0;
  localparam int IDX_READY   = 1;
  localparam int IDX_RING    = 2;
  localparam int IDX_CARRIER = 3;

  // Lines whose flag sets only on a 1->0 move of the status bit
  localparam logic [LINES-1:0] FALL_ONLY_MASK = LINES'(1) << IDX_RING;

  typedef logic [LINES-1:0] line_vec_t;

  // Map modem-control bits onto status positions for loopback
  function automatic line_vec_t loop_map(input line_vec_t ctl);
    line_vec_t m;
    m[IDX_CARRIER] = ctl[3];
    m[IDX_RING]    = ctl[2];
    m[IDX_READY]   = ctl[0];
    m[IDX_SEND]    = ctl[1];
    return m;
  endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[LAST];
  end

endmodule

// File: rtl/mdm_src_sel.sv
module mdm_src_sel
  import mdm_stat_pkg::*;
(
  input  line_vec_t pins_sync_i,
  input  logic      loop_en_i,
  input  line_vec_t ctl_i,
  output line_vec_t src_o
);

  // Pins are active-low; status reports asserted lines as 1
  always_comb begin
    if (loop_en_i) src_o = loop_map(ctl_i);
    else           src_o = ~pins_sync_i;
  end

endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
  parameter int           W         = 4,
  parameter logic [W-1:0] FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] chg_o
);

  logic [W-1:0] stat_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;

  for (genvar b = 0; b < W; b++) begin : g_det
    if (FALL_MASK[b]) begin : g_fall
      assign chg_o[b] = stat_q[b] & ~src_i[b];
    end else begin : g_any
      assign chg_o[b] = stat_q[b] ^ src_i[b];
    end
  end

  // New events win over a clearing read in the same cycle
  always_comb flag_d = (flag_q & ~{W{clr_i}}) | chg_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      flag_q <= '0;
    end else begin
      stat_q <= src_i;
      flag_q <= flag_d;
    end
  end

  assign stat_o = stat_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
  import mdm_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mdm_pins_i,
  input  logic       loop_en_i,
  input  logic [3:0] ctl_i,
  input  logic       ien_i,
  input  logic       rd_stb_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o
);

  line_vec_t pins_sync;
  line_vec_t src_v;
  line_vec_t stat_v;
  line_vec_t flag_v;
  line_vec_t chg_v;

  mdm_sync #(
    .W       (LINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ('1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (mdm_pins_i),
    .q_o   (pins_sync)
  );

  mdm_src_sel u_sel (
    .pins_sync_i (pins_sync),
    .loop_en_i   (loop_en_i),
    .ctl_i       (ctl_i),
    .src_o       (src_v)
  );

  mdm_delta #(
    .W         (LINES),
    .FALL_MASK (FALL_ONLY_MASK)
  ) u_delta (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_v),
    .clr_i  (rd_stb_i),
    .stat_o (stat_v),
    .flag_o (flag_v),
    .chg_o  (chg_v)
  );

  assign rd_data_o = {stat_v, flag_v};
  assign irq_o     = ien_i & (|flag_v);

endmodule

// File: rtl/mdm_stat_chk.sv
module mdm_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loop_en_i,
  input logic [3:0] ctl_i,
  input logic       ien_i,
  input logic       rd_stb_i,
  input logic [7:0] rd_data_o,
  input logic       irq_o,
  input logic [3:0] chg_v
);

  // R2: loopback status follows mapped control bits one clock later
  a_r2_loop_map: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en_i |=> rd_data_o[7:4] == {$past(ctl_i[3]), $past(ctl_i[2]),
                                     $past(ctl_i[0]), $past(ctl_i[1])});

  // R3: any move of carrier, ready or send state sets its flag
  a_r3_carrier_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data_o[7]) |-> rd_data_o[3]);
  a_r3_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data_o[5]) |-> rd_data_o[1]);
  a_r3_send_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data_o[4]) |-> rd_data_o[0]);

  // R4: ring flag sets on a fall of bit 6, never on a rise
  a_r4_ring_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data_o[6]) |-> rd_data_o[2]);
  a_r4_ring_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_data_o[6]) && !$past(rd_data_o[2])) |-> !rd_data_o[2]);

  // R5: a read with no new event empties the flags
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && chg_v == 4'b0) |=> rd_data_o[3:0] == 4'b0);

  // R6: an event in the read cycle survives the clear
  a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && chg_v != 4'b0) |=> rd_data_o[3:0] != 4'b0);

  // R7: flags are sticky without a read; interrupt gated by enable
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> (rd_data_o[3:0] & $past(rd_data_o[3:0])) == $past(rd_data_o[3:0]));
  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_i |-> !irq_o);
  a_r7_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_i && rd_data_o[3:0] != 4'b0) |-> irq_o);

endmodule

bind mdm_stat_reg mdm_stat_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .loop_en_i (loop_en_i),
  .ctl_i     (ctl_i),
  .ien_i     (ien_i),
  .rd_stb_i  (rd_stb_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .chg_v     (chg_v)
);

// File: tb/mdm_stat_reg_bench.sv
`timescale 1ns/1ps
module mdm_stat_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mdm_pins_i = 4'hF;
  logic       loop_en_i = 1'b0;
  logic [3:0] ctl_i = 4'h0;
  logic       ien_i = 1'b0;
  logic       rd_stb_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;   // 250 MHz

  mdm_stat_reg u_mdm_stat_reg (
    .clk(clk), .rst_n(rst_n), .mdm_pins_i(mdm_pins_i), .loop_en_i(loop_en_i),
    .ctl_i(ctl_i), .ien_i(ien_i), .rd_stb_i(rd_stb_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Driver: one read cycle, expected value queued for the monitor
  task automatic rd(input string tag, input logic [7:0] exp);
    @(negedge clk);
    rd_stb_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_stb_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk); #1;
    check(tag, {7'b0, irq_o}, {7'b0, exp});
  endtask

  // Monitor: compare during every read cycle, before the clearing edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rd_stb_i && rst_n) begin
        if (exp_q.size() == 0) check("queue underflow", 8'h00, 8'h01);
        else check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    #1;
    check("R8 reset register", rd_data_o, 8'h00);
    check("R8 reset irq", {7'b0, irq_o}, 8'h00);
    rd("R8 reset read", 8'h00);

    // R1/R3: carrier asserted (pin low)
    @(negedge clk); mdm_pins_i[3] = 1'b0; idle(4);
    rd("R1 R3 carrier on", 8'h88);
    rd("R5 flags cleared", 8'h80);

    // R7: interrupt with enable
    ien_i = 1'b1;
    @(negedge clk); mdm_pins_i[1] = 1'b0; idle(4);
    irq_chk("R7 irq raised", 1'b1);
    rd("R1 R3 ready on", 8'hA2);
    irq_chk("R7 irq dropped after read", 1'b0);

    // R4: ring pin falls (status rises): no flag
    @(negedge clk); mdm_pins_i[2] = 1'b0; idle(4);
    rd("R4 ring rise no flag", 8'hE0);
    @(negedge clk); mdm_pins_i[2] = 1'b1; idle(4);
    rd("R4 ring trailing edge", 8'hA4);
    rd("R5 ring flag cleared", 8'hA0);

    // R3: carrier back off (other direction)
    @(negedge clk); mdm_pins_i[3] = 1'b1; idle(4);
    rd("R3 carrier off", 8'h28);

    // R3 send line, then R7 with enable low
    @(negedge clk); mdm_pins_i[0] = 1'b0; idle(4);
    rd("R3 send on", 8'h31);
    ien_i = 1'b0;
    @(negedge clk); mdm_pins_i[0] = 1'b1; idle(4);
    irq_chk("R7 irq gated off", 1'b0);
    rd("R7 flag set while disabled", 8'h21);

    // R6: edge lands in the read cycle (pin -> register is 3 clocks)
    @(negedge clk); mdm_pins_i[3] = 1'b0;
    @(negedge clk);
    rd("R6 pre-clear value", 8'h20);
    rd("R6 flag survives read", 8'hA8);

    // R9/R2: enter loopback with control bits all 0
    @(negedge clk); ctl_i = 4'b0000; loop_en_i = 1'b1; idle(2);
    rd("R9 enter loopback", 8'h0A);
    @(negedge clk); ctl_i = 4'b0010; idle(2);
    rd("R2 ctl1 to bit4", 8'h11);
    @(negedge clk); ctl_i = 4'b1101; idle(2);
    rd("R2 ctl3 ctl2 ctl0 map", 8'hEB);
    @(negedge clk); ctl_i = 4'b1001; idle(2);
    rd("R4 loopback ring fall", 8'hA4);
    // R2: pins ignored in loopback
    @(negedge clk); mdm_pins_i[0] = 1'b0; idle(4);
    rd("R2 pin ignored", 8'hA0);
    @(negedge clk); mdm_pins_i[0] = 1'b1; idle(4);
    rd("R2 pin ignored again", 8'hA0);
    // R9: leave loopback, sources agree
    @(negedge clk); loop_en_i = 1'b0; idle(2);
    rd("R9 leave loopback no change", 8'hA0);

    idle(3);
    if (exp_q.size() != 0) check("queue drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end

endmodule